// File: doc/BRIEF.md
# Transmit Completion Ring Producer

The block writes transmit completion records into circular rings held in memory outside it. Each record is eight 32-bit words. It takes one record per accepted handshake, decides which ring it belongs to, and writes the whole record into the next free slot of that ring in a single write cycle. There are two rings. The completion ring receives the records that are in good order. The error ring receives the records that carry the internal-error flag.

On the completion ring, the top four bits of the last word hold a pass number. This value increments each time the write index wraps. A consumer polling the ring can therefore tell a newly written slot from one left over from the previous pass. It does so by comparing the lowest bit of that field, with no need to read the producer's write index. On the error ring, the same four bits hold an error code. That code is either computed by the block or passed through from the incoming record.

Each ring has its own write index and its own consumer read pointer (tail). A ring is full when advancing its write index would make the index equal that tail. While a record is aimed at a full ring, the input is held off. A record aimed at the other ring is not affected.

Top module: `cmpl_ring_producer`

## Requirements
- R1: A written entry is the input record (word w on bits 32w+31:32w) with every bit unchanged, except word 2 bit 31 (the error flag) and word 7 bits 31:28 (the stamp field).
- R2: Each accepted record produces exactly one write. A record with its error flag set after classification goes to the error ring and all others go to the completion ring. Word 2 bit 31 of the written entry is 1 on the error ring and 0 on the completion ring.
- R3: Word 2 bits 8:6 give the pointer kind: 0 is a plain buffer and any other value is a link descriptor. `in_action` 1 means "return to the idle link list" and 0 means "return to the buffer pool". A plain buffer with action 1 sets the error flag with code 1. A link descriptor with action 0 sets the error flag with code 2.
- R4: A record that arrives with word 2 bit 31 already set, and whose kind and action agree, goes to the error ring with its own word 7 bits 31:28 kept as the error code.
- R5: Completion-ring entries written during the n-th pass through the ring (n counted from 1) carry n mod 16 in word 7 bits 31:28. The first pass writes 1, and the pass after 15 writes 0.
- R6: Each ring writes slots 0, 1, 2 … DEPTH-1 in order and then returns to 0. The two rings advance independently.
- R7: A ring is full when its next write index equals its tail input. `in_ready` is low exactly when the present record targets a full ring.
- R8: A record accepted on a clock edge appears on the write port in the cycle after that edge. The ring's new-entry output pulses high for one cycle, one cycle after the write.
- R9: While reset is high and right after it, no write enable or new-entry pulse is active. Both indices and the pass count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Record valid |
| in_ready | output | 1 | Record accepted when high together with in_valid |
| in_desc | input | 256 | Eight-word record, word 0 in the low bits |
| in_action | input | 1 | 1: to idle link list, 0: to buffer pool |
| cmpl_tail | input | $clog2(CMPL_DEPTH) | Consumer read pointer of the completion ring |
| err_tail | input | $clog2(ERR_DEPTH) | Consumer read pointer of the error ring |
| cmpl_wr_en | output | 1 | Completion ring write strobe |
| cmpl_wr_idx | output | $clog2(CMPL_DEPTH) | Completion ring slot |
| cmpl_wr_data | output | 256 | Completion ring entry |
| cmpl_new | output | 1 | New completion entry pulse |
| err_wr_en | output | 1 | Error ring write strobe |
| err_wr_idx | output | $clog2(ERR_DEPTH) | Error ring slot |
| err_wr_data | output | 256 | Error ring entry |
| err_new | output | 1 | New error entry pulse |

## Verification
Two situations share a cycle here, and both need to be exercised. The first is a record arriving for one ring while the other ring is full. The bench freezes one ring's tail until `in_ready` drops, then offers records for the other ring. It expects those to be accepted at once, and it expects the blocked record to go through in the same cycle the tail is released. The second is the write that wraps the completion ring, which is also the write where the pass number changes. Enough back-to-back records are sent to wrap past pass 15. The model checks every stamp, index and pulse on every clock.

// File: rtl/cmpl_ring_pkg.sv
`timescale 1ns/1ps
package cmpl_ring_pkg;

    localparam int WORD_W   = 32;
    localparam int N_WORDS  = 8;
    localparam int ENTRY_W  = WORD_W * N_WORDS;

    // Field positions that the ring consumer decodes
    localparam int ERR_WORD   = 2;
    localparam int ERR_BIT    = 31;
    localparam int KIND_WORD  = 2;
    localparam int KIND_LSB   = 6;
    localparam int KIND_W     = 3;
    localparam int STAMP_WORD = 7;
    localparam int STAMP_LSB  = 28;
    localparam int STAMP_W    = 4;

    typedef logic [N_WORDS-1:0][WORD_W-1:0] entry_t;
    typedef logic [STAMP_W-1:0]             stamp_t;

    typedef enum logic {
        ACT_BUF_POOL  = 1'b0,
        ACT_LINK_LIST = 1'b1
    } act_e;

    localparam stamp_t ECODE_BUF_TO_LINK = 4'd1;
    localparam stamp_t ECODE_LINK_TO_BUF = 4'd2;

    typedef struct packed {
        logic   to_err;
        stamp_t code;
    } route_t;

    function automatic logic kind_is_link(entry_t e);
        return e[KIND_WORD][KIND_LSB +: KIND_W] != '0;
    endfunction

    function automatic entry_t put_stamp(entry_t e, stamp_t v);
        entry_t r;
        r = e;
        r[STAMP_WORD][STAMP_LSB +: STAMP_W] = v;
        return r;
    endfunction

endpackage

// File: rtl/cmpl_classify.sv
`timescale 1ns/1ps
module cmpl_classify
    import cmpl_ring_pkg::*;
(
    input  entry_t desc,
    input  act_e   action,
    output route_t route,
    output entry_t body
);
    logic is_link;
    logic mm_buf_to_link;
    logic mm_link_to_buf;

    always_comb begin
        is_link        = kind_is_link(desc);
        mm_buf_to_link = !is_link && (action == ACT_LINK_LIST);
        mm_link_to_buf =  is_link && (action == ACT_BUF_POOL);

        route.to_err = desc[ERR_WORD][ERR_BIT] | mm_buf_to_link | mm_link_to_buf;
        if (mm_buf_to_link)
            route.code = ECODE_BUF_TO_LINK;
        else if (mm_link_to_buf)
            route.code = ECODE_LINK_TO_BUF;
        else
            route.code = desc[STAMP_WORD][STAMP_LSB +: STAMP_W];

        body = desc;
        body[ERR_WORD][ERR_BIT] = route.to_err;
    end
endmodule

// File: rtl/ring_ctrl.sv
`timescale 1ns/1ps
module ring_ctrl
    import cmpl_ring_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter bit STAMP_EN = 1'b1,
    localparam int IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [IW-1:0] tail,
    input  stamp_t        alt_stamp,
    output logic [IW-1:0] idx,
    output logic          full,
    output stamp_t        stamp
);
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    logic [IW-1:0] idx_nxt;
    logic          wraps;
    stamp_t        lap_part;

    assign wraps   = (idx == LAST);
    assign idx_nxt = wraps ? '0 : idx + 1'b1;
    assign full    = (idx_nxt == tail);

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (push)
            idx <= idx_nxt;
    end

    generate
        if (STAMP_EN) begin : g_lap
            stamp_t laps;
            always_ff @(posedge clk) begin
                if (rst)
                    laps <= '0;
                else if (push && wraps)
                    laps <= laps + 1'b1;
            end
            assign lap_part = laps + 1'b1;
        end else begin : g_no_lap
            assign lap_part = '0;
        end
    endgenerate

    assign stamp = lap_part ^ alt_stamp;
endmodule

// File: rtl/ring_wport.sv
`timescale 1ns/1ps
module ring_wport
    import cmpl_ring_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [IW-1:0] idx_in,
    input  entry_t        entry_in,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output entry_t        wr_data,
    output logic          new_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_en     <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
            new_pulse <= 1'b0;
        end else begin
            wr_en     <= accept;
            new_pulse <= wr_en;
            if (accept) begin
                wr_idx  <= idx_in;
                wr_data <= entry_in;
            end
        end
    end
endmodule

// File: rtl/cmpl_ring_producer.sv
`timescale 1ns/1ps
module cmpl_ring_producer
    import cmpl_ring_pkg::*;
#(
    parameter int CMPL_DEPTH = 8,
    parameter int ERR_DEPTH  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [255:0]                  in_desc,
    input  logic                          in_action,
    input  logic [$clog2(CMPL_DEPTH)-1:0] cmpl_tail,
    input  logic [$clog2(ERR_DEPTH)-1:0]  err_tail,
    output logic                          cmpl_wr_en,
    output logic [$clog2(CMPL_DEPTH)-1:0] cmpl_wr_idx,
    output logic [255:0]                  cmpl_wr_data,
    output logic                          cmpl_new,
    output logic                          err_wr_en,
    output logic [$clog2(ERR_DEPTH)-1:0]  err_wr_idx,
    output logic [255:0]                  err_wr_data,
    output logic                          err_new
);
    localparam int CIW = $clog2(CMPL_DEPTH);
    localparam int EIW = $clog2(ERR_DEPTH);

    entry_t   desc;
    route_t   route;
    entry_t   body;
    logic     accept;
    logic     c_push, e_push;
    logic     c_full, e_full;
    logic [CIW-1:0] c_idx;
    logic [EIW-1:0] e_idx;
    stamp_t   c_stamp, e_stamp;
    entry_t   c_entry, e_entry;
    entry_t   c_wdata, e_wdata;

    assign desc = entry_t'(in_desc);

    cmpl_classify u_classify (
        .desc   (desc),
        .action (act_e'(in_action)),
        .route  (route),
        .body   (body)
    );

    assign in_ready = route.to_err ? !e_full : !c_full;
    assign accept   = in_valid && in_ready;
    assign c_push   = accept && !route.to_err;
    assign e_push   = accept &&  route.to_err;

    ring_ctrl #(.DEPTH(CMPL_DEPTH), .STAMP_EN(1'b1)) u_cmpl_ctrl (
        .clk       (clk),
        .rst       (rst),
        .push      (c_push),
        .tail      (cmpl_tail),
        .alt_stamp ('0),
        .idx       (c_idx),
        .full      (c_full),
        .stamp     (c_stamp)
    );

    ring_ctrl #(.DEPTH(ERR_DEPTH), .STAMP_EN(1'b0)) u_err_ctrl (
        .clk       (clk),
        .rst       (rst),
        .push      (e_push),
        .tail      (err_tail),
        .alt_stamp (route.code),
        .idx       (e_idx),
        .full      (e_full),
        .stamp     (e_stamp)
    );

    assign c_entry = put_stamp(body, c_stamp);
    assign e_entry = put_stamp(body, e_stamp);

    ring_wport #(.IW(CIW)) u_cmpl_wport (
        .clk       (clk),
        .rst       (rst),
        .accept    (c_push),
        .idx_in    (c_idx),
        .entry_in  (c_entry),
        .wr_en     (cmpl_wr_en),
        .wr_idx    (cmpl_wr_idx),
        .wr_data   (c_wdata),
        .new_pulse (cmpl_new)
    );

    ring_wport #(.IW(EIW)) u_err_wport (
        .clk       (clk),
        .rst       (rst),
        .accept    (e_push),
        .idx_in    (e_idx),
        .entry_in  (e_entry),
        .wr_en     (err_wr_en),
        .wr_idx    (err_wr_idx),
        .wr_data   (e_wdata),
        .new_pulse (err_new)
    );

    assign cmpl_wr_data = c_wdata;
    assign err_wr_data  = e_wdata;
endmodule

// File: rtl/cmpl_ring_producer_chk.sv
`timescale 1ns/1ps
module cmpl_ring_producer_chk #(
    parameter int CMPL_DEPTH = 8,
    parameter int ERR_DEPTH  = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          in_valid,
    input logic                          in_ready,
    input logic [$clog2(CMPL_DEPTH)-1:0] cmpl_tail,
    input logic [$clog2(ERR_DEPTH)-1:0]  err_tail,
    input logic                          cmpl_wr_en,
    input logic [$clog2(CMPL_DEPTH)-1:0] cmpl_wr_idx,
    input logic [255:0]                  cmpl_wr_data,
    input logic                          cmpl_new,
    input logic                          err_wr_en,
    input logic [$clog2(ERR_DEPTH)-1:0]  err_wr_idx,
    input logic [255:0]                  err_wr_data,
    input logic                          err_new
);
    localparam int CIW = $clog2(CMPL_DEPTH);
    localparam int EIW = $clog2(ERR_DEPTH);
    localparam logic [CIW-1:0] CLAST = CIW'(CMPL_DEPTH - 1);
    localparam logic [EIW-1:0] ELAST = EIW'(ERR_DEPTH - 1);

    logic [CIW-1:0] exp_cidx;
    logic [EIW-1:0] exp_eidx;
    logic [3:0]     exp_pass;
    logic [CIW-1:0] c_after;
    logic [EIW-1:0] e_after;

    assign c_after = (cmpl_wr_idx == CLAST) ? '0 : cmpl_wr_idx + 1'b1;
    assign e_after = (err_wr_idx  == ELAST) ? '0 : err_wr_idx  + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_cidx <= '0;
            exp_eidx <= '0;
            exp_pass <= 4'd1;
        end else begin
            if (cmpl_wr_en) begin
                exp_cidx <= (exp_cidx == CLAST) ? '0 : exp_cidx + 1'b1;
                if (exp_cidx == CLAST)
                    exp_pass <= exp_pass + 1'b1;
            end
            if (err_wr_en)
                exp_eidx <= (exp_eidx == ELAST) ? '0 : exp_eidx + 1'b1;
        end
    end

    assert_one_write_R2: assert property (@(posedge clk) disable iff (rst)
        !(cmpl_wr_en && err_wr_en));
    assert_cmpl_clean_R2: assert property (@(posedge clk) disable iff (rst)
        cmpl_wr_en |-> !cmpl_wr_data[95]);
    assert_err_flagged_R2: assert property (@(posedge clk) disable iff (rst)
        err_wr_en |-> err_wr_data[95]);
    assert_write_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (cmpl_wr_en || err_wr_en));
    assert_cmpl_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        cmpl_wr_en |=> cmpl_new);
    assert_cmpl_pulse_only_R8: assert property (@(posedge clk) disable iff (rst)
        !cmpl_wr_en |=> !cmpl_new);
    assert_err_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        err_wr_en |=> err_new);
    assert_no_overrun_R7: assert property (@(posedge clk) disable iff (rst)
        cmpl_wr_en |-> (c_after != $past(cmpl_tail)));
    assert_no_err_overrun_R7: assert property (@(posedge clk) disable iff (rst)
        err_wr_en |-> (e_after != $past(err_tail)));
    assert_cmpl_order_R6: assert property (@(posedge clk) disable iff (rst)
        cmpl_wr_en |-> (cmpl_wr_idx == exp_cidx));
    assert_err_order_R6: assert property (@(posedge clk) disable iff (rst)
        err_wr_en |-> (err_wr_idx == exp_eidx));
    assert_pass_stamp_R5: assert property (@(posedge clk) disable iff (rst)
        cmpl_wr_en |-> (cmpl_wr_data[255:252] == exp_pass));
endmodule

bind cmpl_ring_producer cmpl_ring_producer_chk #(
    .CMPL_DEPTH (CMPL_DEPTH),
    .ERR_DEPTH  (ERR_DEPTH)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .cmpl_tail    (cmpl_tail),
    .err_tail     (err_tail),
    .cmpl_wr_en   (cmpl_wr_en),
    .cmpl_wr_idx  (cmpl_wr_idx),
    .cmpl_wr_data (cmpl_wr_data),
    .cmpl_new     (cmpl_new),
    .err_wr_en    (err_wr_en),
    .err_wr_idx   (err_wr_idx),
    .err_wr_data  (err_wr_data),
    .err_new      (err_new)
);

// File: tb/cmpl_ring_producer_bench.sv
`timescale 1ns/1ps
module cmpl_ring_producer_bench;
    localparam int CD  = 8;
    localparam int ED  = 4;
    localparam int CIW = $clog2(CD);
    localparam int EIW = $clog2(ED);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [255:0]   in_desc = '0;
    logic           in_action = 1'b0;
    logic [CIW-1:0] cmpl_tail = '0;
    logic [EIW-1:0] err_tail = '0;
    logic           cmpl_wr_en, cmpl_new, err_wr_en, err_new;
    logic [CIW-1:0] cmpl_wr_idx;
    logic [EIW-1:0] err_wr_idx;
    logic [255:0]   cmpl_wr_data, err_wr_data;

    always #4 clk = ~clk;

    cmpl_ring_producer #(.CMPL_DEPTH(CD), .ERR_DEPTH(ED)) u_cmpl_ring_producer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_desc(in_desc), .in_action(in_action),
        .cmpl_tail(cmpl_tail), .err_tail(err_tail),
        .cmpl_wr_en(cmpl_wr_en), .cmpl_wr_idx(cmpl_wr_idx),
        .cmpl_wr_data(cmpl_wr_data), .cmpl_new(cmpl_new),
        .err_wr_en(err_wr_en), .err_wr_idx(err_wr_idx),
        .err_wr_data(err_wr_data), .err_new(err_new)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // reference model state
    int m_cidx = 0, m_eidx = 0, m_passes = 0;
    bit c_drain = 1, e_drain = 1;
    logic         x_c_en = 0, x_c_new = 0, x_e_en = 0, x_e_new = 0;
    int           x_c_idx = 0, x_e_idx = 0;
    logic [255:0] x_c_data = '0, x_e_data = '0;
    int           n_acc_c = 0, n_acc_e = 0;

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [255:0] mk_desc(input int kind, input bit err_in);
        logic [255:0] d;
        for (int w = 0; w < 8; w++) d[32*w +: 32] = $urandom;
        d[72:70] = 3'(kind);
        d[95]    = err_in;
        return d;
    endfunction

    task automatic step(input logic v, input logic [255:0] d, input logic a);
        bit link, mm1, mm2, is_err, full_c, full_e, exp_rdy;
        logic [3:0] code;
        logic [255:0] e;
        in_valid  = v;
        in_desc   = d;
        in_action = a;
        if (c_drain) cmpl_tail = CIW'(m_cidx);
        if (e_drain) err_tail  = EIW'(m_eidx);
        #1;
        link   = d[72:70] != 3'd0;
        mm1    = !link && a;
        mm2    = link && !a;
        is_err = d[95] || mm1 || mm2;
        code   = mm1 ? 4'd1 : (mm2 ? 4'd2 : d[255:252]);
        full_c = ((m_cidx + 1) % CD) == int'(cmpl_tail);
        full_e = ((m_eidx + 1) % ED) == int'(err_tail);
        exp_rdy = is_err ? !full_e : !full_c;
        chk(in_ready == exp_rdy, "R7 in_ready", 256'(in_ready), 256'(exp_rdy));
        x_c_new = x_c_en;
        x_e_new = x_e_en;
        x_c_en  = 0;
        x_e_en  = 0;
        if (v && exp_rdy) begin
            e = d;
            e[95] = is_err;
            if (is_err) begin
                e[255:252] = code;
                x_e_en = 1; x_e_idx = m_eidx; x_e_data = e;
                m_eidx = (m_eidx + 1) % ED;
                n_acc_e++;
            end else begin
                e[255:252] = 4'((m_passes + 1) % 16);
                x_c_en = 1; x_c_idx = m_cidx; x_c_data = e;
                if (m_cidx == CD - 1) m_passes++;
                m_cidx = (m_cidx + 1) % CD;
                n_acc_c++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(cmpl_wr_en == x_c_en, "R2 completion write enable", 256'(cmpl_wr_en), 256'(x_c_en));
        chk(err_wr_en == x_e_en, "R2 error write enable", 256'(err_wr_en), 256'(x_e_en));
        chk(cmpl_new == x_c_new, "R8 completion new pulse", 256'(cmpl_new), 256'(x_c_new));
        chk(err_new == x_e_new, "R8 error new pulse", 256'(err_new), 256'(x_e_new));
        if (cmpl_wr_en && x_c_en) begin
            chk(int'(cmpl_wr_idx) == x_c_idx, "R6 completion index", 256'(cmpl_wr_idx), 256'(x_c_idx));
            chk(cmpl_wr_data[251:0] == x_c_data[251:0], "R1 completion body", cmpl_wr_data, x_c_data);
            chk(cmpl_wr_data[255:252] == x_c_data[255:252], "R5 pass stamp",
                256'(cmpl_wr_data[255:252]), 256'(x_c_data[255:252]));
        end
        if (err_wr_en && x_e_en) begin
            chk(int'(err_wr_idx) == x_e_idx, "R6 error index", 256'(err_wr_idx), 256'(x_e_idx));
            chk(err_wr_data[251:0] == x_e_data[251:0], "R1 error body", err_wr_data, x_e_data);
            chk(err_wr_data[255:252] == x_e_data[255:252], "R3 R4 error code",
                256'(err_wr_data[255:252]), 256'(x_e_data[255:252]));
        end
    endtask

    task automatic good(input logic v);
        int k;
        k = $urandom % 5;
        step(v, mk_desc(k, 1'b0), k != 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(!cmpl_wr_en && !err_wr_en, "R9 no write in reset", 256'({cmpl_wr_en, err_wr_en}), 256'(0));
        chk(!cmpl_new && !err_new, "R9 no pulse in reset", 256'({cmpl_new, err_new}), 256'(0));
        chk(in_ready == 1'b1, "R9 ready after reset", 256'(in_ready), 256'(1));
        rst = 1'b0;
        @(negedge clk);
        chk(!cmpl_wr_en && !err_wr_en && !cmpl_new && !err_new, "R9 quiet after reset",
            256'({cmpl_wr_en, err_wr_en, cmpl_new, err_new}), 256'(0));

        // phase A: mixed good traffic with gaps (R1, R5, R6, R8)
        for (int i = 0; i < 24; i++) good(i % 5 != 4);

        // phase B: completion ring full while error entries pass (R7, R2)
        c_drain = 0;
        for (int i = 0; i < CD + 2; i++) begin
            if (i == 4) step(1'b1, mk_desc(0, 1'b0), 1'b1);
            good(1'b1);
        end
        good(1'b1);
        c_drain = 1;
        good(1'b1);

        // phase C: error classification (R3, R4)
        for (int i = 0; i < 6; i++) begin
            step(1'b1, mk_desc(0, 1'b0), 1'b1);
            step(1'b1, mk_desc(1 + (i % 4), 1'b0), 1'b0);
            step(1'b1, mk_desc(0, 1'b1), 1'b0);
            step(1'b1, mk_desc(2, 1'b1), 1'b1);
        end
        // error ring full, completion still flows (R7)
        e_drain = 0;
        for (int i = 0; i < ED + 2; i++) begin
            step(1'b1, mk_desc(3, 1'b0), 1'b0);
            good(1'b1);
        end
        e_drain = 1;
        step(1'b1, mk_desc(0, 1'b0), 1'b1);

        // phase D: long run to wrap the pass stamp past 15 (R5, R6)
        for (int i = 0; i < 16 * CD + 8; i++) good(1'b1);
        good(1'b0);
        good(1'b0);

        chk(m_passes >= 16, "R5 stamp wrap reached", 256'(m_passes), 256'(16));
        chk(n_acc_e > 0 && n_acc_c > 0, "R2 both rings written", 256'(n_acc_e), 256'(1));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule